// File: doc/BRIEF.md
# Accumulator Rounding Readout Unit

This block turns a set of wide per-lane accumulator values into one packed 64-bit result. Each lane is shifted right by its own count, rounded by the selected method, and then saturated to the lane width. It has two formats. In halfword format, four signed 48-bit accumulators produce four 16-bit lanes. In byte format, eight 24-bit accumulators produce eight unsigned 8-bit lanes. The block reads the accumulators as inputs and never writes them back.

A 3-bit mode picks the rounding method and whether the accumulator is treated as signed or unsigned. The methods are round-half-away, round-half-even and truncate. The shift count comes from one of three places: a packed per-lane vector, one lane of that vector broadcast to all lanes, or a 5-bit immediate. The block has two pipeline stages, and a valid bit travels with the data. An unpredictable flag marks operations whose result is undefined.

Top module: `acc_round_readout`

## Requirements
- R1: A request accepted with `in_valid` high on clock edge k gives `out_valid` high with its result after edge k+1. Idle cycles give `out_valid` low. After reset, `out_valid` is 0 and `out_data` is 0.
- R2: Mode 0 is signed round-half-away (halfword only), with shift count s. For a non-negative accumulator, one is added to the shifted value when bit s-1 is set. For a negative accumulator, one is added only when bit s-1 is set and some bit below s-1 is also set.
- R3: Modes 2 (signed) and 3 (unsigned) round half to even. When bit s-1 is set and a lower bit is also set, one is added. On an exact tie, the LSB of the shifted value is added.
- R4: Modes 4 (signed) and 5 (unsigned) truncate, using an arithmetic shift when signed and a logical shift when unsigned.
- R5: Signed results saturate to -32768..32767. Unsigned results saturate to 65535 in halfword format and to 255 in byte format.
- R6: The odd modes 1, 3 and 5 treat the accumulator as an unsigned 48-bit or 24-bit value. Mode 1 rounds half away from zero.
- R7: In signed modes, a count above 47 gives 0. The exception is mode 0, which gives 0 only above 48.
- R8: In unsigned modes, a count above the accumulator width W gives 0. At a count equal to W, the result depends on the mode and format:
  - Mode 1 returns the accumulator MSB.
  - Mode 3, and mode 5 in halfword format, return 1 only when the accumulator exceeds 2^(W-1).
  - Mode 5 in byte format returns 0 for any count of 24 or more.
- R9: In halfword format, a count from the vector or a broadcast lane is read as signed 16-bit. Each lane with a negative count outputs 16'hDEAD and raises `out_unpred`.
- R10: Modes 6 and 7 are illegal in both formats, and modes 0, 2 and 4 are illegal in byte format. An illegal mode raises `out_unpred` and gives `out_data` of 0.
- R11: The count select is encoded as follows:
  - `in_csel` 2'b10 takes lane i's count from the vector: bits [16i+15:16i] in halfword format, bits [8i+7:8i] in byte format.
  - `in_csel` 2'b00 or 2'b01 broadcasts vector lane `in_lane` to all lanes. Halfword format uses only `in_lane[1:0]`.
  - `in_csel` 2'b11 gives every lane the non-negative count `in_imm`.
- R12: Lane i takes its accumulator from `in_acc[48i+47:48i]` in halfword format, or from `in_acc[24i+23:24i]` in byte format. Its result goes to `out_data[16i+15:16i]` or `out_data[8i+7:8i]` respectively.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request valid |
| in_half | input | 1 | 1 selects halfword format, 0 selects byte format |
| in_mode | input | 3 | Rounding and signedness mode |
| in_csel | input | 2 | Shift count source select |
| in_lane | input | 3 | Broadcast lane index |
| in_imm | input | 5 | Immediate shift count |
| in_cnt_vec | input | 64 | Packed per-lane shift counts |
| in_acc | input | 192 | Packed accumulators |
| out_valid | output | 1 | Result valid |
| out_data | output | 64 | Packed rounded lanes |
| out_unpred | output | 1 | Result is unpredictable |

## Verification
Every result is due two clock edges after the request is presented. The first edge captures the shifted and rounded lanes, and the second captures the saturated and packed word. The bench drives each request on a falling edge and keeps its expected results in a two-entry shift register that advances on every falling edge. On each falling edge it compares `out_valid`, and for valid entries also `out_data` and `out_unpred`, against the entry pushed two falling edges earlier. Back-to-back requests and idle gaps are therefore checked in the exact cycle they are due.

// File: rtl/acc_rro_pkg.sv
package acc_rro_pkg;

    parameter int unsigned VEC_W      = 64;
    parameter int unsigned H_LANES    = 4;
    parameter int unsigned B_LANES    = 8;
    parameter int unsigned H_ACC_W    = 48;
    parameter int unsigned B_ACC_W    = 24;
    parameter int unsigned IMM_W      = 5;
    localparam int unsigned H_W        = VEC_W / H_LANES;
    localparam int unsigned B_W        = VEC_W / B_LANES;
    localparam int unsigned CNT_W      = H_W;
    localparam int unsigned T_W        = H_ACC_W + 2;
    localparam int unsigned ACC_BUS_W  = H_LANES * H_ACC_W;
    localparam int unsigned LANE_SEL_W = $clog2(B_LANES);

    localparam logic [H_W-1:0] DEAD_PAT = 16'hDEAD;

    localparam logic [2:0] MD_AWAY_S  = 3'd0;
    localparam logic [2:0] MD_AWAY_U  = 3'd1;
    localparam logic [2:0] MD_EVEN_S  = 3'd2;
    localparam logic [2:0] MD_EVEN_U  = 3'd3;
    localparam logic [2:0] MD_TRUNC_S = 3'd4;
    localparam logic [2:0] MD_TRUNC_U = 3'd5;

    typedef enum logic [1:0] {
        CS_BCAST_A = 2'b00,
        CS_BCAST_B = 2'b01,
        CS_VEC     = 2'b10,
        CS_IMM     = 2'b11
    } cnt_sel_e;

    typedef logic signed [T_W-1:0] pre_t;

    localparam pre_t ONE_T  = pre_t'(1);
    localparam pre_t S_MAX  = pre_t'(32767);
    localparam pre_t S_MIN  = pre_t'(-32768);
    localparam pre_t UH_MAX = pre_t'(65535);
    localparam pre_t UB_MAX = pre_t'(255);

    typedef struct packed {
        logic                          vld;
        logic                          half;
        logic [2:0]                    mode;
        logic [B_LANES-1:0]            neg;
        logic [B_LANES-1:0][T_W-1:0]   val;
    } s1_t;

    function automatic logic mode_illegal(input logic half, input logic [2:0] mode);
        return (mode > MD_TRUNC_U) || (!half && !mode[0]);
    endfunction

    // Shift and round one lane; corner counts yield their final small value.
    function automatic pre_t round_core(input logic [H_ACC_W-1:0] ua,
                                        input logic half,
                                        input logic [2:0] mode,
                                        input logic [CNT_W-1:0] s);
        int         si;
        int         w;
        logic [T_W-1:0] uext;
        pre_t       sa;
        logic [T_W-1:0] tmp;
        logic [T_W-1:0] lowmask;
        logic [T_W-1:0] halfbit;
        logic       rb;
        logic       sticky;
        logic       top;
        pre_t       t;
        si   = int'(s);
        w    = half ? int'(H_ACC_W) : int'(B_ACC_W);
        uext = {2'b00, ua};
        sa   = half ? $signed({{2{ua[H_ACC_W-1]}}, ua}) : $signed(uext);
        rb = 1'b0;
        if (si > 0 && si <= w) begin
            tmp = uext >> (si - 1);
            rb  = tmp[0];
        end
        sticky = 1'b0;
        if (si > 1 && si <= w) begin
            lowmask = ({{(T_W-1){1'b0}}, 1'b1} << (si - 1)) - {{(T_W-1){1'b0}}, 1'b1};
            sticky  = |(uext & lowmask);
        end
        tmp     = uext >> (w - 1);
        top     = tmp[0];
        halfbit = {{(T_W-1){1'b0}}, 1'b1} << (w - 1);
        t = '0;
        case (mode)
            MD_AWAY_S: if (si <= 48) begin
                t = sa >>> si;
                if (!ua[H_ACC_W-1]) begin
                    if (rb) t = t + ONE_T;
                end else if (rb && sticky) begin
                    t = t + ONE_T;
                end
            end
            MD_EVEN_S: if (si <= 47) begin
                t = sa >>> si;
                if (rb) begin
                    if (si == 1 || !sticky) begin
                        if (t[0]) t = t + ONE_T;
                    end else begin
                        t = t + ONE_T;
                    end
                end
            end
            MD_TRUNC_S: if (si <= 47) t = sa >>> si;
            MD_AWAY_U: begin
                if (si == w) t = $signed({{(T_W-1){1'b0}}, top});
                else if (si < w) begin
                    t = $signed(uext >> si);
                    if (rb) t = t + ONE_T;
                end
            end
            MD_EVEN_U: begin
                if (si == w) t = $signed({{(T_W-1){1'b0}}, (uext > halfbit)});
                else if (si < w) begin
                    t = $signed(uext >> si);
                    if (rb) begin
                        if (sticky) t = t + ONE_T;
                        else if (t[0]) t = t + ONE_T;
                    end
                end
            end
            MD_TRUNC_U: begin
                if (half && si == w) t = $signed({{(T_W-1){1'b0}}, (uext > halfbit)});
                else if (si < w) t = $signed(uext >> si);
            end
            default: t = '0;
        endcase
        return t;
    endfunction

    function automatic logic [H_W-1:0] sat_lane(input pre_t t, input logic sgn, input logic half);
        pre_t lim;
        if (sgn) begin
            if (t > S_MAX) return S_MAX[H_W-1:0];
            if (t < S_MIN) return S_MIN[H_W-1:0];
            return t[H_W-1:0];
        end
        lim = half ? UH_MAX : UB_MAX;
        if (t > lim) return lim[H_W-1:0];
        return t[H_W-1:0];
    endfunction

endpackage

// File: rtl/acc_rro_cnt_sel.sv
module acc_rro_cnt_sel
    import acc_rro_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          half,
    input  logic [1:0]                    csel,
    input  logic [LANE_SEL_W-1:0]         lane,
    input  logic [IMM_W-1:0]              imm,
    input  logic [VEC_W-1:0]              cvec,
    output logic [B_LANES-1:0][CNT_W-1:0] cnt,
    output logic [B_LANES-1:0]            neg
);

    for (genvar g = 0; g < B_LANES; g++) begin : g_lane
        logic [CNT_W-1:0] c_l;
        logic             n_l;
        always_comb begin
            int src;
            if (csel[1]) src = g;
            else         src = half ? (int'(lane) % H_LANES) : int'(lane);
            if (csel == CS_IMM) begin
                c_l = {{(CNT_W-IMM_W){1'b0}}, imm};
            end else if (half) begin
                c_l = cvec[(src % H_LANES)*H_W +: H_W];
            end else begin
                c_l = {{(CNT_W-B_W){1'b0}}, cvec[src*B_W +: B_W]};
            end
            n_l = half && (csel != CS_IMM) && c_l[CNT_W-1] && (g < H_LANES);
        end
        assign cnt[g] = c_l;
        assign neg[g] = n_l;
    end

    AST_BCAST_SAME: assert property (@(posedge clk) disable iff (rst)
        (!csel[1]) |-> (cnt[0] == cnt[1] && cnt[0] == cnt[2])); // R11
    AST_IMM_NONNEG: assert property (@(posedge clk) disable iff (rst)
        (csel == CS_IMM) |-> (neg == '0)); // R11

endmodule

// File: rtl/acc_rro_round_stage.sv
module acc_rro_round_stage
    import acc_rro_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          in_valid,
    input  logic                          half,
    input  logic [2:0]                    mode,
    input  logic [ACC_BUS_W-1:0]          acc,
    input  logic [B_LANES-1:0][CNT_W-1:0] cnt,
    input  logic [B_LANES-1:0]            neg,
    output s1_t                           q
);

    logic [B_LANES-1:0][T_W-1:0] val_w;

    for (genvar g = 0; g < B_LANES; g++) begin : g_lane
        logic [H_ACC_W-1:0] ua;
        if (g < H_LANES) begin : g_dual
            assign ua = half ? acc[g*H_ACC_W +: H_ACC_W]
                             : {{(H_ACC_W-B_ACC_W){1'b0}}, acc[g*B_ACC_W +: B_ACC_W]};
        end else begin : g_byte
            assign ua = {{(H_ACC_W-B_ACC_W){1'b0}}, acc[g*B_ACC_W +: B_ACC_W]};
        end
        assign val_w[g] = round_core(ua, half, mode, cnt[g]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            q.vld  <= in_valid;
            q.half <= half;
            q.mode <= mode;
            q.neg  <= neg;
            q.val  <= val_w;
        end
    end

    AST_S1_FOLLOW: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> q.vld); // R1
    AST_S1_IDLE: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !q.vld); // R1

endmodule

// File: rtl/acc_rro_sat_pack.sv
module acc_rro_sat_pack
    import acc_rro_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  s1_t              d,
    output logic             out_valid,
    output logic [VEC_W-1:0] out_data,
    output logic             out_unpred
);

    logic [VEC_W-1:0] hw_pack;
    logic [VEC_W-1:0] b_pack;
    logic             illegal;
    logic             sgn;

    assign illegal = mode_illegal(d.half, d.mode);
    assign sgn     = !d.mode[0];

    for (genvar g = 0; g < H_LANES; g++) begin : g_h
        logic [H_W-1:0] s_l;
        assign s_l = sat_lane($signed(d.val[g]), sgn, 1'b1);
        assign hw_pack[g*H_W +: H_W] = d.neg[g] ? DEAD_PAT : s_l;
    end

    for (genvar g = 0; g < B_LANES; g++) begin : g_b
        logic [H_W-1:0] s_l;
        assign s_l = sat_lane($signed(d.val[g]), 1'b0, 1'b0);
        assign b_pack[g*B_W +: B_W] = s_l[B_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid  <= 1'b0;
            out_data   <= '0;
            out_unpred <= 1'b0;
        end else begin
            out_valid  <= d.vld;
            out_data   <= illegal ? '0 : (d.half ? hw_pack : b_pack);
            out_unpred <= illegal || (d.half && (|d.neg[H_LANES-1:0]));
        end
    end

    AST_OUT_FOLLOW: assert property (@(posedge clk) disable iff (rst)
        d.vld |=> out_valid); // R1
    AST_DEAD_LANE: assert property (@(posedge clk) disable iff (rst)
        (d.vld && d.half && !illegal && d.neg[0]) |=> (out_unpred && out_data[H_W-1:0] == DEAD_PAT)); // R9
    AST_ILLEGAL_ZERO: assert property (@(posedge clk) disable iff (rst)
        (d.vld && illegal) |=> (out_unpred && out_data == '0)); // R10
    AST_BYTE_EVEN_BAD: assert property (@(posedge clk) disable iff (rst)
        (d.vld && !d.half && !d.mode[0]) |=> out_unpred); // R10

endmodule

// File: rtl/acc_round_readout.sv
module acc_round_readout
    import acc_rro_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  in_valid,
    input  logic                  in_half,
    input  logic [2:0]            in_mode,
    input  logic [1:0]            in_csel,
    input  logic [LANE_SEL_W-1:0] in_lane,
    input  logic [IMM_W-1:0]      in_imm,
    input  logic [VEC_W-1:0]      in_cnt_vec,
    input  logic [ACC_BUS_W-1:0]  in_acc,
    output logic                  out_valid,
    output logic [VEC_W-1:0]      out_data,
    output logic                  out_unpred
);

    logic [B_LANES-1:0][CNT_W-1:0] cnt;
    logic [B_LANES-1:0]            neg;
    s1_t                           s1;

    acc_rro_cnt_sel u_cnt (
        .clk  (clk),
        .rst  (rst),
        .half (in_half),
        .csel (in_csel),
        .lane (in_lane),
        .imm  (in_imm),
        .cvec (in_cnt_vec),
        .cnt  (cnt),
        .neg  (neg)
    );

    acc_rro_round_stage u_round (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .half     (in_half),
        .mode     (in_mode),
        .acc      (in_acc),
        .cnt      (cnt),
        .neg      (neg),
        .q        (s1)
    );

    acc_rro_sat_pack u_sat (
        .clk        (clk),
        .rst        (rst),
        .d          (s1),
        .out_valid  (out_valid),
        .out_data   (out_data),
        .out_unpred (out_unpred)
    );

endmodule

// File: tb/acc_round_readout_bench.sv
module acc_round_readout_bench;

    typedef struct {
        bit         vld;
        bit         half;
        bit [2:0]   mode;
        bit [1:0]   csel;
        bit [2:0]   lane;
        bit [4:0]   imm;
        bit [63:0]  cv;
        bit [191:0] acc;
        string      tag;
    } stim_t;

    typedef struct {
        bit        vld;
        bit [63:0] data;
        bit        unp;
        string     tag;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic         in_half = 1'b0;
    logic [2:0]   in_mode = '0;
    logic [1:0]   in_csel = '0;
    logic [2:0]   in_lane = '0;
    logic [4:0]   in_imm = '0;
    logic [63:0]  in_cnt_vec = '0;
    logic [191:0] in_acc = '0;
    logic         out_valid;
    logic [63:0]  out_data;
    logic         out_unpred;

    int total = 0;
    int bad = 0;
    bit chk_en = 0;
    exp_t pipe0, pipe1;

    always #5 clk = ~clk;

    acc_round_readout u_acc_round_readout (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_half(in_half),
        .in_mode(in_mode), .in_csel(in_csel), .in_lane(in_lane), .in_imm(in_imm),
        .in_cnt_vec(in_cnt_vec), .in_acc(in_acc),
        .out_valid(out_valid), .out_data(out_data), .out_unpred(out_unpred)
    );

    function automatic longint unsigned ref_lane(bit half, int mode, longint unsigned a, int s);
        int w = half ? 48 : 24;
        longint unsigned m = (64'd1 << w) - 1;
        longint unsigned ua = a & m;
        longint sa = half ? (longint'(ua << 16) >>> 16) : longint'(ua);
        longint unsigned umax = half ? 65535 : 255;
        bit rb = 0, st = 0;
        longint t;
        longint unsigned u;
        if (s > 0 && s <= w) rb = ((ua >> (s - 1)) & 1) != 0;
        if (s > 1 && s <= w) st = (ua & ((64'd1 << (s - 1)) - 1)) != 0;
        case (mode)
            0, 2, 4: begin
                if (s > ((mode == 0) ? 48 : 47)) return 0;
                t = sa >>> s;
                if (mode == 0) begin
                    if (ua[47] == 0) begin if (rb) t++; end
                    else if (rb && st) t++;
                end else if (mode == 2 && rb) begin
                    if (s == 1 || !st) t += t & 1;
                    else t++;
                end
                if (t > 32767) t = 32767;
                if (t < -32768) t = -32768;
                return longint'(t) & 64'hFFFF;
            end
            default: begin
                if (s > w) return 0;
                if (mode == 5 && !half && s >= 24) return 0;
                if (s == w) begin
                    if (mode == 1) return ua >> (w - 1);
                    return (ua > (64'd1 << (w - 1))) ? 1 : 0;
                end
                u = ua >> s;
                if (mode == 1 && rb) u++;
                if (mode == 3 && rb) begin
                    if (st) u++;
                    else u += u & 1;
                end
                if (u > umax) u = umax;
                return u;
            end
        endcase
    endfunction

    function automatic exp_t model(stim_t st);
        exp_t e;
        int n = st.half ? 4 : 8;
        bit illegal = (st.mode > 5) || (!st.half && st.mode[0] == 0);
        e.vld = st.vld; e.data = '0; e.unp = illegal; e.tag = st.tag;
        for (int i = 0; i < n; i++) begin
            int src, s;
            longint unsigned a, r;
            src = st.csel[1] ? i : (st.half ? (st.lane % 4) : int'(st.lane));
            if (st.csel == 2'b11) s = st.imm;
            else if (st.half) s = int'(shortint'(st.cv[16*src +: 16]));
            else s = int'(st.cv[8*src +: 8]);
            a = st.half ? longint'(st.acc[48*i +: 48]) : longint'(st.acc[24*i +: 24]);
            if (illegal) r = 0;
            else if (st.half && s < 0) begin r = 64'hDEAD; e.unp = 1; end
            else r = ref_lane(st.half, st.mode, a, s);
            if (st.half) e.data[16*i +: 16] = r[15:0];
            else e.data[8*i +: 8] = r[7:0];
        end
        return e;
    endfunction

    task automatic step(stim_t st);
        @(negedge clk);
        if (chk_en) begin
            total++;
            if (out_valid !== pipe1.vld) begin
                bad++;
                $display("FAIL R1 valid: actual=%0b expected=%0b", out_valid, pipe1.vld);
            end
            if (pipe1.vld) begin
                total++;
                if (out_data !== pipe1.data || out_unpred !== pipe1.unp) begin
                    bad++;
                    $display("FAIL %s: actual=%h/%0b expected=%h/%0b",
                             pipe1.tag, out_data, out_unpred, pipe1.data, pipe1.unp);
                end
            end
        end
        pipe1 = pipe0;
        pipe0 = model(st);
        in_valid = st.vld; in_half = st.half; in_mode = st.mode; in_csel = st.csel;
        in_lane = st.lane; in_imm = st.imm; in_cnt_vec = st.cv; in_acc = st.acc;
    endtask

    function automatic bit [191:0] acc4(longint a0, longint a1, longint a2, longint a3);
        return {a3[47:0], a2[47:0], a1[47:0], a0[47:0]};
    endfunction

    function automatic bit [191:0] acc8(int a0, int a1, int a2, int a3, int a4, int a5, int a6, int a7);
        return {a7[23:0], a6[23:0], a5[23:0], a4[23:0], a3[23:0], a2[23:0], a1[23:0], a0[23:0]};
    endfunction

    function automatic bit [63:0] cv4(int c0, int c1, int c2, int c3);
        return {c3[15:0], c2[15:0], c1[15:0], c0[15:0]};
    endfunction

    function automatic bit [63:0] cv8(int c0, int c1, int c2, int c3, int c4, int c5, int c6, int c7);
        return {c7[7:0], c6[7:0], c5[7:0], c4[7:0], c3[7:0], c2[7:0], c1[7:0], c0[7:0]};
    endfunction

    function automatic stim_t mk(bit half, int mode, int csel, int lane, int imm,
                                 bit [63:0] cv, bit [191:0] acc, string tag);
        stim_t s;
        s.vld = 1; s.half = half; s.mode = mode[2:0]; s.csel = csel[1:0];
        s.lane = lane[2:0]; s.imm = imm[4:0]; s.cv = cv; s.acc = acc; s.tag = tag;
        return s;
    endfunction

    stim_t idle;

    initial begin
        idle = '{vld:0, half:0, mode:0, csel:0, lane:0, imm:0, cv:0, acc:0, tag:"idle"};
        pipe0 = '{vld:0, data:0, unp:0, tag:"idle"};
        pipe1 = pipe0;
        repeat (3) step(idle);
        rst = 1'b0;
        step(idle);
        total++;
        if (out_valid !== 1'b0 || out_data !== 64'd0) begin
            bad++;
            $display("FAIL R1 reset: actual=%0b/%h expected=0/0", out_valid, out_data);
        end
        chk_en = 1;
        // R2 signed half-away, ties on both signs
        step(mk(1, 0, 3, 0, 4, 0, acc4(24, -24, -25, 8), "R2 away signed"));
        step(mk(1, 0, 2, 0, 0, cv4(1, 1, 2, 3), acc4(-3, 3, -6, -12), "R2 away small shifts"));
        // R3 half-even ties and above-tie
        step(mk(1, 2, 3, 0, 2, 0, acc4(6, 10, -6, -10), "R3 even signed ties"));
        step(mk(1, 2, 3, 0, 2, 0, acc4(7, 11, -7, 5), "R3 even signed above tie"));
        step(mk(1, 3, 3, 0, 1, 0, acc4(1, 3, 5, 7), "R3 even unsigned half"));
        step(mk(0, 3, 3, 0, 3, 0, acc8(4, 12, 20, 28, 5, 13, 255, 256), "R3 even unsigned byte"));
        // R4 truncation
        step(mk(1, 4, 3, 0, 3, 0, acc4(15, -15, -1, 100), "R4 trunc signed"));
        step(mk(0, 5, 2, 0, 0, cv8(0, 1, 2, 3, 4, 5, 6, 7), acc8(255, 255, 255, 255, 1000, 1000, 1000, 1000), "R4 trunc byte"));
        // R5 saturation
        step(mk(1, 0, 3, 0, 0, 0, acc4(64'h7FFF_FFFF_FFFF, -64'sd100000, 40000, -40000), "R5 signed sat"));
        step(mk(1, 1, 3, 0, 0, 0, acc4(70000, 65535, 131071, 5), "R5 unsigned half sat"));
        step(mk(0, 1, 3, 0, 0, 0, acc8(256, 255, 24'hFFFFFF, 0, 1, 300, 1000, 17), "R5 unsigned byte sat"));
        // R6 unsigned view of negative accumulators
        step(mk(1, 5, 3, 0, 31, 0, acc4(-1, -64'sd2, 64'h8000_0000_0000, 5), "R6 unsigned half"));
        step(mk(1, 1, 3, 0, 31, 0, acc4(-1, 64'h0000_7FFF_FFFF, 64'h0000_4000_0000, 64'h0000_C000_0000), "R6 away unsigned"));
        // R7 large signed counts
        step(mk(1, 0, 2, 0, 0, cv4(47, 48, 49, 60), acc4(-5, -5, -5, 64'h7000_0000_0000), "R7 away signed large"));
        step(mk(1, 0, 2, 0, 0, cv4(48, 48, 47, 48), acc4(64'h4000_0000_0000, -64'sd1, 64'h7FFF_FFFF_FFFF, 64'h8000_0000_0001), "R7 away at 48"));
        step(mk(1, 2, 2, 0, 0, cv4(46, 47, 48, 100), acc4(-5, -5, -5, -5), "R7 even signed large"));
        step(mk(1, 4, 2, 0, 0, cv4(46, 47, 48, 100), acc4(-5, 64'h4000_0000_0000, -5, 9), "R7 trunc signed large"));
        // R8 unsigned at and beyond width
        step(mk(1, 1, 2, 0, 0, cv4(48, 48, 49, 47), acc4(64'h8000_0000_0000, 64'h7FFF_FFFF_FFFF, -1, -1), "R8 away unsigned half"));
        step(mk(1, 3, 2, 0, 0, cv4(48, 48, 49, 47), acc4(64'h8000_0000_0000, 64'h8000_0000_0001, -1, 64'h8000_0000_0000), "R8 even unsigned half"));
        step(mk(1, 5, 2, 0, 0, cv4(48, 48, 49, 47), acc4(64'h8000_0000_0000, 64'h8000_0000_0001, -1, -1), "R8 trunc unsigned half"));
        step(mk(0, 1, 2, 0, 0, cv8(24, 24, 25, 23, 24, 24, 23, 22), acc8(24'h800000, 24'h7FFFFF, 24'hFFFFFF, 24'hFFFFFF, 24'h800001, 0, 24'h400000, 24'h600000), "R8 away unsigned byte"));
        step(mk(0, 3, 2, 0, 0, cv8(24, 24, 25, 23, 24, 24, 23, 22), acc8(24'h800000, 24'h800001, 24'hFFFFFF, 24'h800000, 24'hFFFFFF, 1, 24'hC00000, 24'h600000), "R8 even unsigned byte"));
        step(mk(0, 5, 2, 0, 0, cv8(24, 24, 25, 23, 30, 24, 23, 22), acc8(24'h800001, 24'hFFFFFF, 24'hFFFFFF, 24'hFFFFFF, 24'hFFFFFF, 24'h900000, 24'h800000, 24'hC00000), "R8 trunc unsigned byte"));
        // R9 negative counts
        step(mk(1, 0, 2, 0, 0, cv4(2, -1, 3, -32768), acc4(100, 100, 100, 100), "R9 negative lane"));
        step(mk(1, 4, 0, 1, 0, cv4(0, -2, 0, 0), acc4(1, 2, 3, 4), "R9 negative broadcast"));
        // R10 illegal modes
        step(mk(1, 6, 3, 0, 1, 0, acc4(9, 9, 9, 9), "R10 mode 6"));
        step(mk(1, 7, 3, 0, 1, 0, acc4(9, 9, 9, 9), "R10 mode 7"));
        step(mk(0, 0, 3, 0, 1, 0, acc8(9, 9, 9, 9, 9, 9, 9, 9), "R10 byte signed away"));
        step(mk(0, 2, 3, 0, 1, 0, acc8(9, 9, 9, 9, 9, 9, 9, 9), "R10 byte signed even"));
        step(idle);
        step(mk(0, 4, 3, 0, 1, 0, acc8(9, 9, 9, 9, 9, 9, 9, 9), "R10 byte signed trunc"));
        step(idle);
        step(idle);
        // R11 count sources
        step(mk(1, 5, 0, 6, 0, cv4(1, 2, 3, 4), acc4(256, 256, 256, 256), "R11 broadcast half uses low lane bits"));
        step(mk(0, 5, 1, 5, 0, cv8(0, 1, 2, 3, 4, 5, 6, 7), acc8(255, 254, 253, 252, 251, 250, 249, 248), "R11 broadcast byte"));
        step(mk(0, 5, 3, 0, 4, cv8(7, 7, 7, 7, 7, 7, 7, 7), acc8(16, 32, 48, 64, 80, 96, 112, 128), "R11 immediate byte"));
        step(mk(1, 5, 3, 0, 31, cv4(-1, -1, -1, -1), acc4(64'h0001_0000_0000, 3, 4, 5), "R11 immediate ignores vector"));
        // R12 lane placement, distinct values
        step(mk(1, 4, 3, 0, 0, 0, acc4(1, 2, 3, 4), "R12 half lanes"));
        step(mk(0, 5, 3, 0, 0, 0, acc8(1, 2, 3, 4, 5, 6, 7, 8), "R12 byte lanes"));
        // mixed stream
        for (int k = 0; k < 400; k++) begin
            stim_t s;
            s.vld = ($urandom_range(0, 4) != 0);
            s.half = $urandom_range(0, 1);
            s.mode = $urandom_range(0, 7);
            s.csel = $urandom_range(0, 3);
            s.lane = $urandom_range(0, 7);
            s.imm = $urandom_range(0, 31);
            for (int j = 0; j < 8; j++) s.cv[8*j +: 8] = $urandom_range(0, 9) == 0 ? 8'($urandom) : 8'($urandom_range(0, 26));
            if (s.half && $urandom_range(0, 2) != 0)
                for (int j = 0; j < 4; j++) s.cv[16*j +: 16] = 16'($urandom_range(0, 9) == 0 ? -$urandom_range(1, 5) : $urandom_range(0, 50));
            for (int j = 0; j < 6; j++) s.acc[32*j +: 32] = $urandom;
            s.tag = "R12 mixed stream";
            step(s);
        end
        repeat (3) step(idle);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL R1 watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule